// File: doc/BRIEF.md
# Serial Byte Transmitter with Holding Register

This block turns bytes written by software into asynchronous serial frames on a single output line. A byte goes first into a one-entry holding register. On a bit-rate tick, when the shift stage is idle or is in the last tick of its final stop bit, the pending byte moves into the shifter. The shifter then sends a low start bit, eight data bits with the least significant first, an optional ninth bit and one or two high stop bits. Each bit lasts from one tick to the next. The ninth bit is either a computed parity bit or a bit supplied by software.

The host polls a holding-empty status to learn when it may write again. A sticky transmit flag tells it that the data part of a frame is done; this flag goes up when the first stop bit begins. Bit-rate generation, reception and interrupt routing are handled outside the block. Frame options are taken from the configuration inputs when a byte moves into the shifter, and they stay fixed for that whole frame.

Top module: `uart_tx_hold`

## Requirements
- R1: After reset, `hold_empty_o` is 1, `txint_o` is 0 and `txd_o` is 1.
- R2: A write (`wr_en_i` high for one cycle) while `hold_empty_o` is 1 stores `wr_data_i`, and `hold_empty_o` reads 0 in the following cycle.
- R3: A write while `hold_empty_o` is 0 is ignored. The pending byte is not changed and is the one sent later.
- R4: A pending byte moves into the shifter on the first tick at which the shifter is idle or is ending its last stop bit. `hold_empty_o` goes to 1 in the same cycle that `txd_o` goes low for the start bit. A byte that is pending when a frame ends starts with no idle bit before it.
- R5: A frame is one start bit at 0 followed by eight data bits, least significant bit first. Each bit is held from one `bit_tick_i` pulse to the next.
- R6: With `par_en_i`=0 and `xbit_en_i`=1, the value of `xbit_i` is sent as a ninth bit after the data. With both at 0, no ninth bit is sent.
- R7: With `par_en_i`=1, `xbit_i` is ignored and a parity bit is sent after the data. Its value is the XOR of the eight data bits, inverted when `par_odd_i`=1, so the total number of ones is odd.
- R8: `two_stop_i`=0 sends one stop bit at 1. `two_stop_i`=1 sends two.
- R9: `txint_o` rises on the edge at which the first stop bit begins, and not before.
- R10: `txint_o` stays at 1 until `txint_clr_i` is pulsed. It reads 0 in the cycle after the clear, unless a new stop bit begins in that same cycle, in which case the set wins.
- R11: When no frame is active, `txd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse marking each bit boundary |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Byte to transmit |
| par_en_i | input | 1 | Send a parity bit after the data |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| xbit_en_i | input | 1 | Send `xbit_i` as a ninth bit when parity is off |
| xbit_i | input | 1 | Software value for the ninth bit |
| two_stop_i | input | 1 | 1 selects two stop bits |
| txint_clr_i | input | 1 | Clears the transmit flag |
| txd_o | output | 1 | Serial line, high when idle |
| hold_empty_o | output | 1 | Holding register can accept a byte |
| txint_o | output | 1 | Sticky flag, set when a stop bit begins |

## Verification
The hardest case to reach from the ports is the handover at the end of a frame. Here a pending byte must start on the same tick that ends the last stop bit, with no idle bit in between. Getting there needs a second byte written while the first frame is still being shifted, and a third write made while the register is full. The stimulus does this by watching for the holding-empty rise after the first load, then writing twice inside one bit period. The bit sampled right after the stop bit must then be a start bit carrying the second byte, not the third. Random frames that mix parity, ninth-bit and stop-count settings then cover the frame layouts.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_EXTRA = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic xb_en;
    logic xb_val;
    logic two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          load_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  logic          full_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (load_i) begin
      full_q <= 1'b0;
    end else if (wr_en_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= wr_data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  // R3
  pending_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |=> $stable(data_q));

  // R4
  load_only_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> full_q);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          pend_i,
  input  logic [DW-1:0] pend_data_i,
  input  frame_cfg_t    cfg_i,
  output logic          load_o,
  output logic          stop_enter_o,
  output logic          txd_o
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  tx_state_e     state_q;
  frame_cfg_t    cfg_q;
  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          stop_cnt_q;
  logic          ex_bit_q;
  logic          last_stop;
  logic          has_extra;

  assign last_stop = (state_q == ST_STOP) && (stop_cnt_q == cfg_q.two_stop);
  assign has_extra = cfg_q.par_en | cfg_q.xb_en;
  assign load_o    = tick_i && pend_i && ((state_q == ST_IDLE) || last_stop);
  assign stop_enter_o = tick_i && (((state_q == ST_DATA) && (cnt_q == LAST_BIT) && !has_extra)
                                   || (state_q == ST_EXTRA));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cfg_q      <= '0;
      sh_q       <= '0;
      cnt_q      <= '0;
      stop_cnt_q <= 1'b0;
      ex_bit_q   <= 1'b0;
    end else if (load_o) begin
      state_q  <= ST_START;
      cfg_q    <= cfg_i;
      sh_q     <= pend_data_i;
      ex_bit_q <= cfg_i.par_en ? ((^pend_data_i) ^ cfg_i.par_odd) : cfg_i.xb_val;
    end else if (tick_i) begin
      unique case (state_q)
        ST_START: begin
          state_q <= ST_DATA;
          cnt_q   <= '0;
        end
        ST_DATA: begin
          sh_q <= sh_q >> 1;
          if (cnt_q == LAST_BIT) begin
            state_q    <= has_extra ? ST_EXTRA : ST_STOP;
            stop_cnt_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_EXTRA: begin
          state_q    <= ST_STOP;
          stop_cnt_q <= 1'b0;
        end
        ST_STOP: begin
          if (last_stop) state_q <= ST_IDLE;
          else           stop_cnt_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_EXTRA: txd_o = ex_bit_q;
      default:  txd_o = 1'b1;
    endcase
  end

  // R5
  start_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (txd_o == 1'b0));

  // R8
  stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_enter_o |=> txd_o);

  // R11
  idle_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !tick_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/tx_int_flag.sv
module tx_int_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R10
  sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);

  // R10
  clear_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_tick_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          xbit_en_i,
  input  logic          xbit_i,
  input  logic          two_stop_i,
  input  logic          txint_clr_i,
  output logic          txd_o,
  output logic          hold_empty_o,
  output logic          txint_o
);
  logic          full;
  logic          load;
  logic          stop_enter;
  logic [DW-1:0] pend_data;
  frame_cfg_t    cfg;

  assign cfg = '{par_en: par_en_i, par_odd: par_odd_i, xb_en: xbit_en_i,
                 xb_val: xbit_i, two_stop: two_stop_i};

  tx_hold_reg #(.DW(DW)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .load_i    (load),
    .full_o    (full),
    .data_o    (pend_data)
  );

  tx_shifter #(.DW(DW)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (bit_tick_i),
    .pend_i       (full),
    .pend_data_i  (pend_data),
    .cfg_i        (cfg),
    .load_o       (load),
    .stop_enter_o (stop_enter),
    .txd_o        (txd_o)
  );

  tx_int_flag u_int (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (stop_enter),
    .clr_i  (txint_clr_i),
    .flag_o (txint_o)
  );

  assign hold_empty_o = !full;

  // R4
  empty_with_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_empty_o) |-> !txd_o);

  // R9
  int_at_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txint_o) |-> txd_o);

  // R2
  write_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hold_empty_o) |=> !hold_empty_o);
endmodule

// File: tb/uart_tx_hold_tb.sv
module uart_tx_hold_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic par_en = 0, par_odd = 0, xbit_en = 0, xbit = 0, two_stop = 0;
  logic txint_clr = 0;
  logic txd, hold_empty, txint;

  int total = 0;
  int bad = 0;
  int tick_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tick_cnt <= (tick_cnt == TICK_DIV-1) ? 0 : tick_cnt + 1;
    bit_tick <= (tick_cnt == TICK_DIV-1);
  end

  uart_tx_hold dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(bit_tick),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .par_en_i(par_en), .par_odd_i(par_odd), .xbit_en_i(xbit_en),
    .xbit_i(xbit), .two_stop_i(two_stop), .txint_clr_i(txint_clr),
    .txd_o(txd), .hold_empty_o(hold_empty), .txint_o(txint)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!bit_tick) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // bits after the start bit, LSB first; returns count, pre_stop = bits before stop
  function automatic int exp_frame(input logic [7:0] d, input bit pe, input bit po,
                                   input bit xe, input bit xv, input bit ts,
                                   output logic [11:0] bits, output int pre_stop);
    int n = 0;
    bits = '1;
    for (int i = 0; i < 8; i++) begin bits[n] = d[i]; n++; end
    if (pe) begin bits[n] = (^d) ^ po; n++; end
    else if (xe) begin bits[n] = xv; n++; end
    pre_stop = n;
    bits[n] = 1'b1; n++;
    if (ts) begin bits[n] = 1'b1; n++; end
    return n;
  endfunction

  task automatic check_frame(input logic [7:0] d, input bit immediate);
    logic [11:0] bits;
    int pre, n;
    bit found = 0;
    n = exp_frame(d, par_en, par_odd, xbit_en, xbit, two_stop, bits, pre);
    if (immediate) begin
      wait_tick();
      chk(txd == 1'b0, "R4 start follows stop", txd, 0);
      found = (txd == 1'b0);
    end else begin
      for (int k = 0; k < 64 && !found; k++) begin
        wait_tick();
        if (txd == 1'b0) found = 1;
      end
      chk(found, "R5 start bit seen", found, 1);
    end
    if (!found) return;
    @(negedge clk); txint_clr = 1'b1;
    @(negedge clk); txint_clr = 1'b0;
    for (int i = 0; i < n; i++) begin
      wait_tick();
      if (i < 8)
        chk(txd == bits[i], "R5 data bit", txd, bits[i]);
      else if (i < pre)
        chk(txd == bits[i], par_en ? "R7 parity bit" : "R6 extra bit", txd, bits[i]);
      else
        chk(txd == 1'b1, "R8 stop bit", txd, 1);
      if (i == pre - 1) chk(txint == 1'b0, "R9 flag before stop", txint, 0);
      if (i == pre)     chk(txint == 1'b1, "R9 flag at stop", txint, 1);
    end
  endtask

  task automatic check_idle();
    wait_tick();
    chk(txd == 1'b1, "R11 idle line high", txd, 1);
    chk(hold_empty == 1'b1, "R11 register empty when idle", hold_empty, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(hold_empty == 1'b1, "R1 empty after reset", hold_empty, 1);
    chk(txint == 1'b0, "R1 flag after reset", txint, 0);
    chk(txd == 1'b1, "R1 line after reset", txd, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed: plain 8N1
    write_byte(8'hA5);
    chk(hold_empty == 1'b0, "R2 write fills", hold_empty, 0);
    check_frame(8'hA5, 0);
    check_idle();

    // R10: flag holds without clear, clears on pulse
    repeat (20) @(negedge clk);
    chk(txint == 1'b1, "R10 flag sticky", txint, 1);
    txint_clr = 1'b1; @(negedge clk); txint_clr = 1'b0;
    chk(txint == 1'b0, "R10 flag cleared", txint, 0);

    // back-to-back with ignored write, parity even, two stops
    par_en = 1; par_odd = 0; xbit_en = 1; xbit = 1; two_stop = 1;
    write_byte(8'h3C);
    while (!hold_empty) @(negedge clk);
    chk(txd == 1'b0, "R4 empty rises with start bit", txd, 0);
    write_byte(8'h81);
    write_byte(8'hFF);
    chk(hold_empty == 1'b0, "R3 write while full keeps full", hold_empty, 0);
    check_frame(8'h3C, 0);
    check_frame(8'h81, 1);
    check_idle();

    // extra bit off and on with parity off, odd parity
    par_en = 0; xbit_en = 0; two_stop = 0;
    write_byte(8'h01); check_frame(8'h01, 0); check_idle();
    xbit_en = 1; xbit = 0;
    write_byte(8'hFE); check_frame(8'hFE, 0); check_idle();
    par_en = 1; par_odd = 1; xbit = 1;
    write_byte(8'h00); check_frame(8'h00, 0); check_idle();

    // random frames
    for (int r = 0; r < 24; r++) begin
      d = 8'($urandom);
      par_en = 1'($urandom); par_odd = 1'($urandom);
      xbit_en = 1'($urandom); xbit = 1'($urandom); two_stop = 1'($urandom);
      write_byte(d);
      check_frame(d, 0);
      if (r % 4 == 3) check_idle();
    end
    check_idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule